// File: doc/BRIEF.md
# Transactional Read/Write-Set Conflict Detector

The block follows one core's hardware transaction. Once a transaction is open, every load marks the line slot it touched in a read set, and every store marks its slot in a write set. The store data stays speculative in the cache and is never released to memory by this block. Both sets are 32-bit masks, with one bit per line slot.

While the transaction runs, other cores announce their committed write sets on a broadcast port. If an incoming mask overlaps the local read set, the transaction is lost. The block then emits a one-cycle abort pulse and an invalidate mask that names every speculatively written line.

If the core closes the transaction without such a conflict, the block emits a one-cycle commit request. That request carries the local write set so that it can be broadcast to the other cores. When a conflicting broadcast and the close request arrive in the same cycle, the broadcast is resolved first.

Top module: `txn_conflict_det`

## Requirements
- R1: While a transaction is active, a load with `ld_valid_i` high sets read-set bit k, where k is `ld_slot_i` (slot k maps to mask bit k).
- R2: While a transaction is active, a store with `st_valid_i` high sets write-set bit k, where k is `st_slot_i` (slot k maps to mask bit k).
- R3: While a transaction is active, a broadcast (`bcast_valid_i`) whose mask shares a set bit with the read set raises `abort_o` one cycle later. A broadcast that overlaps only the write set, or nothing at all, does not abort.
- R4: On abort, `inval_mask_o` equals the write set for exactly the one cycle in which `abort_o` is high, and is zero in every other cycle. The transaction ends, so a later `end_i` produces no commit.
- R5: `end_i` during an active transaction raises `commit_o` for one cycle, one cycle later, with `commit_mask_o` equal to the write set. `commit_mask_o` is zero in every other cycle.
- R6: While no transaction is active, broadcasts, loads, stores and `end_i` have no effect, and no abort or commit is produced.
- R7: An accepted `begin_i` clears both sets, so nothing from an earlier transaction reaches a later commit or invalidate mask.
- R8: If `end_i` coincides with a conflicting broadcast, only the abort is produced and the commit is cancelled. If the broadcast does not conflict, the commit proceeds.
- R9: `begin_i` while a transaction is active is ignored. Loads and stores presented in the same cycle as an accepted `begin_i` are not recorded.
- R10: After reset, no transaction is active and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| begin_i | input | 1 | Open a transaction |
| end_i | input | 1 | Close the transaction and request commit |
| ld_valid_i | input | 1 | Load event |
| ld_slot_i | input | 5 | Line slot of the load |
| st_valid_i | input | 1 | Store event |
| st_slot_i | input | 5 | Line slot of the store |
| bcast_valid_i | input | 1 | Remote committed write set is valid |
| bcast_mask_i | input | 32 | Remote committed write set |
| abort_o | output | 1 | One-cycle abort pulse |
| inval_mask_o | output | 32 | Lines to invalidate, valid together with the abort pulse |
| commit_o | output | 1 | One-cycle commit request |
| commit_mask_o | output | 32 | Local write set to broadcast, valid together with the commit request |

## Verification
The hardest situation to reach is a close request that meets a conflicting broadcast in the same cycle. Only that case shows whether the broadcast is resolved first. The stimulus first builds a known read set and write set. It then drives `end_i` together with a broadcast that hits one read slot, and repeats the same step with a broadcast that misses. A broadcast that overlaps only the write set, and broadcasts sent while idle, show at the outputs that the comparison uses the read set and only an active transaction.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int unsigned TM_SLOTS = 32;
  localparam int unsigned TM_SLOT_W = $clog2(TM_SLOTS);

  typedef enum logic {
    TXN_IDLE = 1'b0,
    TXN_RUN  = 1'b1
  } txn_state_e;
endpackage

// File: rtl/tm_set_tracker.sv
module tm_set_tracker #(
  parameter int unsigned N_SLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               add_i,
  input  logic [SLOT_W-1:0]  slot_i,
  output logic [N_SLOTS-1:0] set_o
);
  logic [N_SLOTS-1:0] set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      set_q <= '0;
    else if (clr_i)   set_q <= '0;
    else if (add_i)   set_q <= set_q | (N_SLOTS'(1) << slot_i);
  end

  assign set_o = set_q;

  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (set_q == '0)); // R7
  AST_ADD_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clr_i) |=> set_q[$past(slot_i)]); // R1
endmodule

// File: rtl/tm_conflict_check.sv
module tm_conflict_check #(
  parameter int unsigned N_SLOTS = 32
) (
  input  logic               active_i,
  input  logic               valid_i,
  input  logic [N_SLOTS-1:0] remote_i,
  input  logic [N_SLOTS-1:0] local_i,
  output logic               hit_o
);
  logic [N_SLOTS-1:0] overlap;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_bit
    assign overlap[g] = remote_i[g] & local_i[g];
  end

  // only an active transaction can lose a conflict
  assign hit_o = active_i & valid_i & (|overlap);
endmodule

// File: rtl/txn_conflict_det.sv
module txn_conflict_det
  import tm_pkg::*;
#(
  parameter int unsigned N_SLOTS = TM_SLOTS,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               begin_i,
  input  logic               end_i,
  input  logic               ld_valid_i,
  input  logic [SLOT_W-1:0]  ld_slot_i,
  input  logic               st_valid_i,
  input  logic [SLOT_W-1:0]  st_slot_i,
  input  logic               bcast_valid_i,
  input  logic [N_SLOTS-1:0] bcast_mask_i,
  output logic               abort_o,
  output logic [N_SLOTS-1:0] inval_mask_o,
  output logic               commit_o,
  output logic [N_SLOTS-1:0] commit_mask_o
);
  txn_state_e         state_q, state_d;
  logic               active;
  logic               hit, begin_acc, end_acc, set_clr;
  logic [N_SLOTS-1:0] rd_set, wr_set;
  logic               abort_q, commit_q;
  logic [N_SLOTS-1:0] inval_q, cmask_q;

  assign active    = (state_q == TXN_RUN);
  assign begin_acc = begin_i & ~active;
  assign end_acc   = end_i & active & ~hit;   // remote conflict wins
  assign set_clr   = begin_acc | end_acc | hit;

  tm_set_tracker #(.N_SLOTS(N_SLOTS)) u_rd_set (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (set_clr),
    .add_i  (active & ld_valid_i),
    .slot_i (ld_slot_i),
    .set_o  (rd_set)
  );

  tm_set_tracker #(.N_SLOTS(N_SLOTS)) u_wr_set (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (set_clr),
    .add_i  (active & st_valid_i),
    .slot_i (st_slot_i),
    .set_o  (wr_set)
  );

  tm_conflict_check #(.N_SLOTS(N_SLOTS)) u_check (
    .active_i (active),
    .valid_i  (bcast_valid_i),
    .remote_i (bcast_mask_i),
    .local_i  (rd_set),
    .hit_o    (hit)
  );

  always_comb begin
    state_d = state_q;
    if (hit || end_acc) state_d = TXN_IDLE;
    else if (begin_acc) state_d = TXN_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TXN_IDLE;
      abort_q  <= 1'b0;
      commit_q <= 1'b0;
      inval_q  <= '0;
      cmask_q  <= '0;
    end else begin
      state_q  <= state_d;
      abort_q  <= hit;
      commit_q <= end_acc;
      inval_q  <= hit ? wr_set : '0;
      cmask_q  <= end_acc ? wr_set : '0;
    end
  end

  assign abort_o       = abort_q;
  assign inval_mask_o  = inval_q;
  assign commit_o      = commit_q;
  assign commit_mask_o = cmask_q;

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R4
  AST_INVAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_o |-> (inval_mask_o == '0)); // R4
  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && commit_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !(abort_o || commit_o)); // R6
  AST_BEGIN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_acc |=> (rd_set == '0 && wr_set == '0)); // R7
endmodule

// File: tb/txn_conflict_det_tb.sv
`timescale 1ns/1ps
module txn_conflict_det_tb_top;
  localparam int N = 32;

  typedef struct {
    int          cyc;
    bit          is_abort;
    logic [31:0] mask;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        begin_i = 0, end_i = 0, ld_v = 0, st_v = 0, bc_v = 0;
  logic [4:0]  ld_s = '0, st_s = '0;
  logic [31:0] bc_m = '0;
  logic        abort_o, commit_o;
  logic [31:0] inval_o, cmask_o;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  exp_t q[$];

  // bench model
  bit          m_act = 0;
  logic [31:0] m_rd = '0, m_wr = '0;

  always #2 clk = ~clk;

  txn_conflict_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .begin_i(begin_i), .end_i(end_i),
    .ld_valid_i(ld_v), .ld_slot_i(ld_s), .st_valid_i(st_v), .st_slot_i(st_s),
    .bcast_valid_i(bc_v), .bcast_mask_i(bc_m),
    .abort_o(abort_o), .inval_mask_o(inval_o),
    .commit_o(commit_o), .commit_mask_o(cmask_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp=finished", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (abort_o || commit_o) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R6 unexpected event: act abort=%0b commit=%0b exp=none", abort_o, commit_o);
        end else begin
          exp_t e;
          logic [31:0] m;
          e = q.pop_front();
          m = e.is_abort ? inval_o : cmask_o;
          if (e.cyc != cyc || abort_o != e.is_abort || commit_o == e.is_abort || m != e.mask) begin
            fails++;
            $display("FAIL %s: act cyc=%0d abort=%0b commit=%0b mask=%h exp cyc=%0d abort=%0b mask=%h",
                     e.req, cyc, abort_o, commit_o, m, e.cyc, e.is_abort, e.mask);
          end
        end
      end else if (q.size() != 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++; fails++;
        $display("FAIL %s missing event: act=none exp abort=%0b mask=%h", e.req, e.is_abort, e.mask);
      end
      if (!abort_o && inval_o != 0) begin
        checks++; fails++;
        $display("FAIL R4 inval mask outside abort: act=%h exp=0", inval_o);
      end
      if (!commit_o && cmask_o != 0) begin
        checks++; fails++;
        $display("FAIL R5 commit mask outside commit: act=%h exp=0", cmask_o);
      end
    end
  end

  // driver: apply one cycle of stimulus, push expectations from the model
  task automatic step(input bit b, input bit e, input bit lv, input int ls,
                      input bit sv, input int ss, input bit bv,
                      input logic [31:0] bm, input string req);
    bit hit;
    begin_i = b; end_i = e; ld_v = lv; ld_s = 5'(ls);
    st_v = sv; st_s = 5'(ss); bc_v = bv; bc_m = bm;
    hit = m_act && bv && ((bm & m_rd) != 0);
    if (hit) begin
      q.push_back('{cyc + 1, 1'b1, m_wr, req});
      m_act = 0; m_rd = '0; m_wr = '0;
    end else if (m_act && e) begin
      q.push_back('{cyc + 1, 1'b0, m_wr, req});
      m_act = 0; m_rd = '0; m_wr = '0;
    end else if (m_act) begin
      if (lv) m_rd[ls] = 1'b1;
      if (sv) m_wr[ss] = 1'b1;
    end else if (b) begin
      m_act = 1; m_rd = '0; m_wr = '0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, '0, "R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (abort_o || commit_o || inval_o != 0 || cmask_o != 0) begin
      fails++;
      $display("FAIL R10 reset outputs: act=%b%b %h %h exp=0", abort_o, commit_o, inval_o, cmask_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R6: broadcast, load, store and end while idle have no effect
    step(0, 0, 1, 1, 1, 2, 1, 32'hFFFF_FFFF, "R6");
    step(0, 1, 0, 0, 0, 0, 0, '0, "R6");
    idle(2);

    // R1 R2 R3 R5: write-only overlap does not abort; commit carries write set
    step(1, 0, 0, 0, 0, 0, 0, '0, "R5");
    step(0, 0, 1, 3, 1, 5, 0, '0, "R1");
    step(0, 0, 0, 0, 1, 31, 0, '0, "R2");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0020, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0010, "R3");
    step(0, 1, 0, 0, 0, 0, 0, '0, "R5");
    idle(2);

    // R3 R4: read overlap aborts, later end ignored
    step(1, 0, 0, 0, 0, 0, 0, '0, "R4");
    step(0, 0, 1, 0, 1, 7, 0, '0, "R1");
    step(0, 0, 1, 31, 0, 0, 0, '0, "R1");
    step(0, 0, 0, 0, 0, 0, 1, 32'h8000_0000, "R3");
    step(0, 1, 0, 0, 0, 0, 0, '0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 32'h8000_0000, "R6");
    idle(2);

    // R9: begin while active ignored, sets kept
    step(1, 0, 0, 0, 0, 0, 0, '0, "R9");
    step(0, 0, 0, 0, 1, 2, 0, '0, "R2");
    step(1, 0, 0, 0, 1, 9, 0, '0, "R9");
    step(0, 1, 0, 0, 0, 0, 0, '0, "R9");
    idle(1);

    // R7: fresh transaction starts empty
    step(1, 0, 0, 0, 0, 0, 0, '0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R7");
    step(0, 1, 0, 0, 0, 0, 0, '0, "R7");
    idle(1);

    // R9: events in the begin cycle are not recorded
    step(1, 0, 1, 6, 1, 4, 0, '0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0040, "R9");
    step(0, 1, 0, 0, 0, 0, 0, '0, "R9");
    idle(1);

    // R8: end with conflicting broadcast -> abort only
    step(1, 0, 0, 0, 0, 0, 0, '0, "R8");
    step(0, 0, 1, 10, 1, 11, 0, '0, "R8");
    step(0, 1, 0, 0, 0, 0, 1, 32'h0000_0400, "R8");
    idle(2);

    // R8: end with non-conflicting broadcast -> commit
    step(1, 0, 0, 0, 0, 0, 0, '0, "R8");
    step(0, 0, 1, 10, 1, 20, 0, '0, "R8");
    step(0, 0, 1, 20, 1, 10, 0, '0, "R8");
    step(0, 1, 0, 0, 0, 0, 1, 32'h0000_1000, "R8");
    idle(2);

    // R3: multi-bit broadcast with single overlap while stores continue
    step(1, 0, 0, 0, 0, 0, 0, '0, "R3");
    step(0, 0, 1, 17, 1, 0, 0, '0, "R3");
    step(0, 0, 0, 0, 1, 30, 1, 32'h0002_0F00, "R3");
    idle(3);

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R5 pending expectations: act=%0d exp=0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule